// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps events against a free-running counter. The counter advances once every four clock cycles. Software picks the trigger source with a select input: an external capture pin, or a status flag driven by an analog comparator. A polarity input picks rising or falling transitions. On an active transition, the counter value is copied into a capture register, a capture flag is set, and an interrupt request is raised if enabled.

The captured value is read one byte at a time through a small read port. Reading the upper byte locks the capture register until the lower byte is read, so a 16-bit timestamp never tears. A capture that arrives while the register is locked waits in a one-entry pending slot. Capturing at two edges of the same polarity gives a period. Capturing at edges of opposite polarity gives a pulse width.

Top module: `icap_unit`

## Requirements
- R1: After reset the counter is zero. It increments by one every PRESCALE (default 4) clock cycles and wraps from all-ones to zero. A capture stores the counter value as it stood in the cycle the capture strobe was formed, including across the wrap. CNT_W defaults to 16.
- R2: With src_sel=0 the pin passes through a two-flop synchronizer. edge_rise=1 selects rising edges and edge_rise=0 selects falling edges. Each qualifying edge produces exactly one single-cycle capture strobe. The stored value is the count two cycles after the pin changed.
- R3: With src_sel=1 the comparator flag is the source, sampled with no synchronizer. Its rising edge captures only when edge_rise=1. With edge_rise=0 the comparator never captures.
- R4: The read map is combinational on rd_addr. Address 0 returns status, with the capture flag in bit 7 and all other bits 0. Address 1 returns the upper byte (counter bits CNT_W-1 down to 8, zero-extended). Address 2 returns the low byte. Address 3 returns 0. A read takes effect when rd_en is high at a clock edge.
- R5: Every committed capture sets the capture flag. irq is high while the flag is set and irq_en=1.
- R6: The flag clears on a low-byte read that follows a status read made while the flag was set. If a capture commits in the same cycle as that clearing read, the flag stays set.
- R7: A change of src_sel or edge_rise does not cause a capture, even when the newly selected source differs from the old one.
- R8: A high-byte read locks the capture register until a low-byte read. A capture during the lock is held and commits in the cycle after the low-byte read, setting the flag then.
- R9: A transition of the opposite polarity to the selected one causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_pin | input | 1 | External capture pin, asynchronous |
| cmp_flag | input | 1 | Comparator status flag, synchronous |
| src_sel | input | 1 | 0 = pin source, 1 = comparator source |
| edge_rise | input | 1 | 1 = rising edge, 0 = falling edge |
| irq_en | input | 1 | Capture interrupt enable |
| rd_en | input | 1 | Read strobe; side effects at the clock edge |
| rd_addr | input | 2 | Read address (0 status, 1 high, 2 low) |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench switches the source from the pin to the comparator while the two sources differ. A design that did not reload its edge history on a configuration change would record a spurious capture there. It also drives comparator edges with falling polarity selected, where a design that ignored the rising-only rule would capture.

One test places a capture between the high-byte and low-byte reads. A tearing design would return a low byte from the new value, and a design that dropped the held capture would never set the flag afterwards. Another test lands a capture in the exact cycle of the flag-clearing read, where a naive clear would lose the flag. A final capture is timed to the counter wrap to expose faulty wrap arithmetic.

// File: rtl/icap_pkg.sv
package icap_pkg;
   localparam logic [1:0] ADDR_STAT = 2'd0;
   localparam logic [1:0] ADDR_HIGH = 2'd1;
   localparam logic [1:0] ADDR_LOW  = 2'd2;
   localparam int         STAT_FLAG_BIT = 7;
endpackage

// File: rtl/icap_counter.sv
module icap_counter #(
   parameter int CNT_W    = 16,
   parameter int PRESCALE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             tick,
   output logic [CNT_W-1:0] count
);
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   generate
      if (PRESCALE == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (pre_q == PW'(PRESCALE - 1))
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == PW'(PRESCALE - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (tick)
         count <= count + 1'b1;
   end
endmodule

// File: rtl/icap_edge_detect.sv
module icap_edge_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic cmp,
   input  logic src_sel,
   input  logic edge_rise,
   output logic strobe,
   output logic cfg_change
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_s;
   logic                   src_q, edge_q, prev_q;
   logic                   sel, rise, fall, allowed;

   generate
      genvar i;
      for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sync_q[i] <= 1'b0;
            else if (i == 0)
               sync_q[i] <= pin;
            else
               sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign pin_s      = sync_q[SYNC_STAGES-1];
   assign sel        = src_sel ? cmp : pin_s;
   assign cfg_change = (src_sel != src_q) || (edge_rise != edge_q);
   assign rise       = sel & ~prev_q;
   assign fall       = ~sel & prev_q;
   assign allowed    = !(src_sel && !edge_rise);
   assign strobe     = allowed && !cfg_change && (edge_rise ? rise : fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= 1'b0;
         edge_q <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         src_q  <= src_sel;
         edge_q <= edge_rise;
         prev_q <= sel;
      end
   end
endmodule

// File: rtl/icap_regs.sv
module icap_regs
   import icap_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic             strobe,
   input  logic             rd_en,
   input  logic [1:0]       rd_addr,
   input  logic             irq_en,
   output logic [7:0]       rd_data,
   output logic             irq,
   output logic [CNT_W-1:0] cap_val,
   output logic             flag,
   output logic             lock,
   output logic             commit
);
   logic             pend_q, arm_q;
   logic [CNT_W-1:0] pend_val;
   logic [CNT_W-1:0] commit_val;
   logic [15:0]      cap_ext;
   logic             rd_stat, rd_high, rd_low, direct;

   assign rd_stat = rd_en && (rd_addr == ADDR_STAT);
   assign rd_high = rd_en && (rd_addr == ADDR_HIGH);
   assign rd_low  = rd_en && (rd_addr == ADDR_LOW);

   assign direct     = strobe && !lock;
   assign commit     = direct || (pend_q && !lock);
   assign commit_val = direct ? count : pend_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val  <= '0;
         pend_q   <= 1'b0;
         pend_val <= '0;
         lock     <= 1'b0;
         flag     <= 1'b0;
         arm_q    <= 1'b0;
      end else begin
         if (commit)
            cap_val <= commit_val;

         if (strobe && lock) begin
            pend_q   <= 1'b1;
            pend_val <= count;
         end else if (commit) begin
            pend_q <= 1'b0;
         end

         if (rd_low)
            lock <= 1'b0;
         else if (rd_high)
            lock <= 1'b1;

         if (commit)
            flag <= 1'b1;
         else if (arm_q && rd_low)
            flag <= 1'b0;

         if (rd_low)
            arm_q <= 1'b0;
         else if (rd_stat && flag)
            arm_q <= 1'b1;
      end
   end

   assign cap_ext = 16'(cap_val);
   assign irq     = flag && irq_en;

   always_comb begin
      rd_data = 8'h00;
      case (rd_addr)
         ADDR_STAT: rd_data[STAT_FLAG_BIT] = flag;
         ADDR_HIGH: rd_data = cap_ext[15:8];
         ADDR_LOW:  rd_data = cap_ext[7:0];
         default:   rd_data = 8'h00;
      endcase
   end
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
   parameter int CNT_W       = 16,
   parameter int PRESCALE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cap_pin,
   input  logic       cmp_flag,
   input  logic       src_sel,
   input  logic       edge_rise,
   input  logic       irq_en,
   input  logic       rd_en,
   input  logic [1:0] rd_addr,
   output logic [7:0] rd_data,
   output logic       irq
);
   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
         $error("icap_unit: CNT_W must lie in 9..16");
      end
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("icap_unit: PRESCALE must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("icap_unit: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             cnt_tick;
   logic [CNT_W-1:0] cnt_val;
   logic             cap_strobe, cfg_change;
   logic [CNT_W-1:0] cap_val;
   logic             cap_flag, hi_lock, cap_commit;

   icap_counter #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .count(cnt_val)
   );

   icap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin), .cmp(cmp_flag),
      .src_sel(src_sel), .edge_rise(edge_rise),
      .strobe(cap_strobe), .cfg_change(cfg_change)
   );

   icap_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .count(cnt_val), .strobe(cap_strobe),
      .rd_en(rd_en), .rd_addr(rd_addr), .irq_en(irq_en),
      .rd_data(rd_data), .irq(irq), .cap_val(cap_val), .flag(cap_flag),
      .lock(hi_lock), .commit(cap_commit)
   );
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_tick,
   input logic [CNT_W-1:0] cnt_val,
   input logic             cap_strobe,
   input logic             src_sel,
   input logic             edge_rise,
   input logic             hi_lock,
   input logic             rd_en,
   input logic [1:0]       rd_addr,
   input logic [CNT_W-1:0] cap_val,
   input logic             cap_flag,
   input logic             cap_commit
);
   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_tick |=> cnt_val == CNT_W'($past(cnt_val) + 1'b1));
   // R1
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_tick |=> $stable(cnt_val));
   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe |=> !cap_strobe);
   // R3
   cmp_fall_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel && !edge_rise) |-> !cap_strobe);
   // R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_commit |=> cap_flag);
   // R7
   cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_sel != $past(src_sel)) || (edge_rise != $past(edge_rise))) |-> !cap_strobe);
   // R8
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_lock && !(rd_en && rd_addr == 2'd2)) |=> $stable(cap_val));
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
   .cap_strobe(cap_strobe), .src_sel(src_sel), .edge_rise(edge_rise),
   .hi_lock(hi_lock), .rd_en(rd_en), .rd_addr(rd_addr), .cap_val(cap_val),
   .cap_flag(cap_flag), .cap_commit(cap_commit)
);

// File: tb/icap_unit_test.sv
module icap_unit_test;
   localparam int W = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cap_pin = 1'b0, cmp_flag = 1'b0, src_sel = 1'b0;
   logic       edge_rise = 1'b1, irq_en = 1'b1, rd_en = 1'b0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       irq;

   int unsigned cyc = 0;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;
   logic [15:0] exp_q[$];
   logic [15:0] last_cap = 16'h0;

   icap_unit #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .cmp_flag(cmp_flag),
      .src_sel(src_sel), .edge_rise(edge_rise), .irq_en(irq_en),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] wrap(input int unsigned v);
      return 16'(v % (1 << W));
   endfunction

   // driver: pin edge, expected count two cycles later (R2)
   task automatic drive_pin(input logic v, output logic [15:0] e);
      @(negedge clk);
      e = wrap((cyc + 2) / 4);
      cap_pin = v;
   endtask

   task automatic drive_cmp(input logic v, output logic [15:0] e);
      @(negedge clk);
      e = wrap(cyc / 4);
      cmp_flag = v;
   endtask

   // monitor: read a capture and compare against the scoreboard
   task automatic check_capture(input string req);
      logic [7:0]  s, h, l;
      logic [15:0] e;
      rd(2'd0, s);
      check(s == 8'h80, {req, " R5 flag set"}, s, 8'h80);
      check(irq == 1'b1, {req, " R5 irq"}, irq, 1);
      rd(2'd1, h);
      rd(2'd2, l);
      if (exp_q.size() == 0) begin
         check(1'b0, {req, " scoreboard empty"}, 0, 1);
      end else begin
         e = exp_q.pop_front();
         check({h, l} == e, {req, " R4 captured value"}, {h, l}, e);
      end
      last_cap = {h, l};
      rd(2'd0, s);
      check(s == 8'h00, {req, " R6 flag cleared"}, s, 0);
      check(irq == 1'b0, {req, " R6 irq low"}, irq, 0);
   endtask

   task automatic no_capture(input string req);
      logic [7:0] s;
      rd(2'd0, s);
      check(s == 8'h00, {req, " no capture"}, s, 0);
      check(irq == 1'b0, {req, " no irq"}, irq, 0);
   endtask

   initial begin
      logic [7:0]  d;
      logic [15:0] e, ea, eb;
      wait_cyc(3);
      rst_n = 1'b1;

      // reset state (R1, R4)
      rd(2'd0, d); check(d == 8'h00, "R4 reset status", d, 0);
      rd(2'd1, d); check(d == 8'h00, "R1 reset high", d, 0);
      rd(2'd2, d); check(d == 8'h00, "R1 reset low", d, 0);
      rd(2'd3, d); check(d == 8'h00, "R4 reserved", d, 0);
      check(irq == 1'b0, "R5 reset irq", irq, 0);

      // rising pin capture (R2)
      wait_cyc(7);
      drive_pin(1'b1, e); exp_q.push_back(e); wait_cyc(4);
      check_capture("R2 rise");
      // falling transition in rising mode (R9)
      drive_pin(1'b0, e); wait_cyc(5);
      no_capture("R9");
      // second rising capture, later count (R1 rate)
      wait_cyc(13);
      drive_pin(1'b1, e); exp_q.push_back(e); wait_cyc(4);
      check_capture("R1 rate");

      // switch to falling (R7), then falling capture (R2)
      @(negedge clk); edge_rise = 1'b0; wait_cyc(4);
      no_capture("R7 edge change");
      drive_pin(1'b0, e); exp_q.push_back(e); wait_cyc(4);
      check_capture("R2 fall");

      // source switch where sources differ (R7)
      @(negedge clk); edge_rise = 1'b1; wait_cyc(2);
      @(negedge clk); cmp_flag = 1'b1; wait_cyc(3);
      @(negedge clk); src_sel = 1'b1; wait_cyc(4);
      no_capture("R7 source change");

      // comparator source (R3)
      drive_cmp(1'b0, e); wait_cyc(3);
      no_capture("R9 cmp fall");
      drive_cmp(1'b1, e); exp_q.push_back(e); wait_cyc(3);
      check_capture("R3 cmp rise");
      @(negedge clk); edge_rise = 1'b0; wait_cyc(2);
      drive_cmp(1'b0, e); wait_cyc(3);
      drive_cmp(1'b1, e); wait_cyc(3);
      no_capture("R3 cmp falling mode");

      // back to pin, rising, pin is low
      @(negedge clk); src_sel = 1'b0; edge_rise = 1'b1; wait_cyc(4);

      // lock window (R8)
      rd(2'd1, d);
      check(d == last_cap[15:8], "R8 high before", d, last_cap[15:8]);
      drive_pin(1'b1, e); exp_q.push_back(e); wait_cyc(6);
      no_capture("R8 held off");
      rd(2'd2, d);
      check(d == last_cap[7:0], "R8 low untorn", d, last_cap[7:0]);
      wait_cyc(2);
      check_capture("R8 pending commit");

      // flag clear colliding with a capture (R6)
      drive_pin(1'b0, e); wait_cyc(4);
      drive_pin(1'b1, ea); wait_cyc(4);
      rd(2'd0, d); check(d == 8'h80, "R6 arm read", d, 8'h80);
      drive_pin(1'b0, e); wait_cyc(4);
      drive_pin(1'b1, eb);
      @(negedge clk);
      rd(2'd2, d);
      check(d == ea[7:0], "R6 low of earlier capture", d, ea[7:0]);
      wait_cyc(1);
      rd(2'd0, d); check(d == 8'h80, "R6 flag kept", d, 8'h80);
      exp_q.push_back(eb);
      check_capture("R6 collided capture");

      // counter wrap (R1)
      drive_pin(1'b0, e);
      while (cyc < 4070) @(negedge clk);
      drive_pin(1'b1, e); exp_q.push_back(e); wait_cyc(4);
      check_capture("R1 near top");
      drive_pin(1'b0, e);
      while (cyc < 4093) @(negedge clk);
      drive_pin(1'b1, e); exp_q.push_back(e);
      check(e == 16'h0000, "R1 wrap expectation", e, 0);
      wait_cyc(4);
      check_capture("R1 wrap");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule